// File: doc/BRIEF.md
# Block-Counted Byte Transfer Engine

This engine moves data between a card data port that carries one byte at a time and a buffer of 16-bit words. Each word holds two bytes, the earlier byte in bits 7:0 and the later byte in bits 15:8. A transfer consists of a programmed number of blocks, and each block consists of a programmed number of bytes. Both amounts are written as the value minus one in 11-bit fields. When a block has an odd length, its last word is only half filled.

Software first programs the block length and the block count. It then pulses `start_i` with the direction selected. The engine moves at most one byte per cycle, and only while the card port signals ready and the buffer can take or give data. When the last byte of the last block has moved, the engine goes inactive and raises a sticky done flag. The running byte and block counters are visible on the outputs at all times.

Top module: `blk_byte_engine`

## Requirements
- R1: After reset, both running counters read 1, the engine is inactive, done is 0, and no strobe is asserted.
- R2: A length write with field L sets the programmed length to L+1 and loads the running byte counter with L+1 on the next edge.
- R3: A count write with field N sets the programmed count to N+1 and loads the running block counter with N+1. It also reloads the running byte counter with the programmed length. If a length write arrives in the same cycle, the new length is the one used.
- R4: In receive mode (`dir_i`=1), the first byte of a word is stored in bits 7:0 and the second byte in bits 15:8. The word is pushed in the same cycle that its second byte is taken.
- R5: When a block ends on the first byte of a word, that word is pushed with bits 15:8 equal to zero. The next block then starts a fresh word.
- R6: In transmit mode (`dir_i`=0), bits 7:0 of the head word are sent first and bits 15:8 second, and the head word is popped with the second byte. At the end of an odd-length block, the word is popped after its low byte alone.
- R7: In receive mode, a new word is not started while the buffer fill is greater than the almost-full level. A word that has already been started always completes. In transmit mode, no byte is sent while the buffer fill is zero.
- R8: No byte moves while the engine is inactive or while `card_rdy_i` is low. A read strobe and a write strobe are never asserted together.
- R9: After the last byte of a block, the byte counter reloads to the programmed length and the block counter decrements.
- R10: After the last byte of the last block, the block counter reloads to the programmed count, the engine goes inactive, and done is set. Done stays set until the next start.
- R11: No byte moves in a cycle that carries a length write, a count write or a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| len_we_i | input | 1 | Block length write strobe |
| len_val_i | input | 11 | Block length minus one |
| cnt_we_i | input | 1 | Block count write strobe |
| cnt_val_i | input | 11 | Block count minus one |
| start_i | input | 1 | Start a transfer |
| dir_i | input | 1 | 1 = receive from card, 0 = transmit to card |
| af_level_i | input | 5 | Almost-full level for receive |
| buf_fill_i | input | 6 | Words currently in the buffer |
| buf_head_i | input | 16 | Head word of the buffer |
| buf_push_o | output | 1 | Push a word into the buffer |
| buf_push_data_o | output | 16 | Word being pushed |
| buf_pop_o | output | 1 | Pop the head word |
| card_rdy_i | input | 1 | Card port can move a byte this cycle |
| card_rx_data_i | input | 8 | Byte offered by the card |
| card_rd_o | output | 1 | Card byte taken this cycle |
| card_tx_data_o | output | 8 | Byte sent to the card |
| card_wr_o | output | 1 | Card byte sent this cycle |
| byte_cnt_o | output | 12 | Running byte counter |
| blk_cnt_o | output | 12 | Running block counter |
| active_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Sticky end-of-transfer flag |

## Verification
The strobes and data on both the card side and the buffer side are combinational. They are due in the same cycle as the inputs that allow a move. The counters, `active_o` and `done_o` change on the next rising edge after the move or write. The bench drives inputs just after a rising edge and compares every output at the falling edge against a behavioural model. The model advances its state at that same falling edge, so registered outputs are compared one cycle after their cause. The buffer stand-in applies pushes and pops just after the following rising edge.

// File: rtl/bbe_pkg.sv
package bbe_pkg;
  typedef enum logic {
    XFER_TX = 1'b0,
    XFER_RX = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/bbe_counters.sv
module bbe_counters #(
  parameter int LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             len_we_i,
  input  logic [LEN_W-1:0] len_val_i,
  input  logic             cnt_we_i,
  input  logic [LEN_W-1:0] cnt_val_i,
  input  logic             step_i,
  output logic [LEN_W:0]   byte_cnt_o,
  output logic [LEN_W:0]   blk_cnt_o,
  output logic             last_byte_o,
  output logic             last_blk_o
);
  localparam int CW = LEN_W + 1;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] blen_q, nblk_q, bcnt_q, kcnt_q;
  logic [CW-1:0] blen_n, nblk_n;

  always_comb begin
    blen_n = len_we_i ? CW'(len_val_i) + ONE : blen_q;
    nblk_n = CW'(cnt_val_i) + ONE;
  end

  assign last_byte_o = (bcnt_q == ONE);
  assign last_blk_o  = (kcnt_q == ONE);
  assign byte_cnt_o  = bcnt_q;
  assign blk_cnt_o   = kcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blen_q <= ONE;
      nblk_q <= ONE;
      bcnt_q <= ONE;
      kcnt_q <= ONE;
    end else begin
      if (len_we_i) blen_q <= blen_n;
      if (cnt_we_i) nblk_q <= nblk_n;
      if (cnt_we_i) begin
        kcnt_q <= nblk_n;
        bcnt_q <= blen_n;
      end else if (len_we_i) begin
        bcnt_q <= blen_n;
      end else if (step_i) begin
        if (last_byte_o) begin
          bcnt_q <= blen_q;
          kcnt_q <= last_blk_o ? nblk_q : kcnt_q - ONE;
        end else begin
          bcnt_q <= bcnt_q - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/bbe_flow.sv
module bbe_flow
  import bbe_pkg::*;
#(
  parameter int FILL_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic              hold_i,
  input  logic              card_rdy_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic [FILL_W-2:0] af_level_i,
  input  logic              last_byte_i,
  input  logic              last_blk_i,
  output logic              move_o,
  output xfer_dir_e         dir_o,
  output logic              phase_o,
  output logic              active_o,
  output logic              done_o
);
  xfer_dir_e dir_q;
  logic      phase_q, active_q, done_q, room;

  // receive checks the threshold only when a new word begins
  always_comb begin
    if (dir_q == XFER_RX) room = phase_q || (fill_i <= {1'b0, af_level_i});
    else                  room = (fill_i != '0);
    move_o = active_q && card_rdy_i && !hold_i && !start_i && room;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= XFER_TX;
      phase_q  <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (start_i) begin
      dir_q    <= xfer_dir_e'(dir_i);
      phase_q  <= 1'b0;
      active_q <= 1'b1;
      done_q   <= 1'b0;
    end else if (move_o) begin
      phase_q <= !phase_q && !last_byte_i;
      if (last_byte_i && last_blk_i) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end

  assign dir_o    = dir_q;
  assign phase_o  = phase_q;
  assign active_o = active_q;
  assign done_o   = done_q;
endmodule

// File: rtl/bbe_packer.sv
module bbe_packer
  import bbe_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                move_i,
  input  xfer_dir_e           dir_i,
  input  logic                phase_i,
  input  logic                last_byte_i,
  input  logic [BYTE_W-1:0]   rx_data_i,
  input  logic [2*BYTE_W-1:0] head_i,
  output logic                card_rd_o,
  output logic                card_wr_o,
  output logic [BYTE_W-1:0]   tx_data_o,
  output logic                push_o,
  output logic [2*BYTE_W-1:0] push_data_o,
  output logic                pop_o
);
  logic [BYTE_W-1:0] lo_q;
  logic              word_end;

  assign word_end    = phase_i || last_byte_i;
  assign card_rd_o   = move_i && (dir_i == XFER_RX);
  assign card_wr_o   = move_i && (dir_i == XFER_TX);
  assign push_o      = card_rd_o && word_end;
  assign pop_o       = card_wr_o && word_end;
  assign push_data_o = phase_i ? {rx_data_i, lo_q} : {{BYTE_W{1'b0}}, rx_data_i};
  assign tx_data_o   = phase_i ? head_i[2*BYTE_W-1:BYTE_W] : head_i[BYTE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      lo_q <= '0;
    else if (card_rd_o && !phase_i)   lo_q <= rx_data_i;
  end
endmodule

// File: rtl/blk_byte_engine.sv
module blk_byte_engine
  import bbe_pkg::*;
#(
  parameter int LEN_W  = 11,
  parameter int FILL_W = 6,
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                len_we_i,
  input  logic [LEN_W-1:0]    len_val_i,
  input  logic                cnt_we_i,
  input  logic [LEN_W-1:0]    cnt_val_i,
  input  logic                start_i,
  input  logic                dir_i,
  input  logic [FILL_W-2:0]   af_level_i,
  input  logic [FILL_W-1:0]   buf_fill_i,
  input  logic [2*BYTE_W-1:0] buf_head_i,
  output logic                buf_push_o,
  output logic [2*BYTE_W-1:0] buf_push_data_o,
  output logic                buf_pop_o,
  input  logic                card_rdy_i,
  input  logic [BYTE_W-1:0]   card_rx_data_i,
  output logic                card_rd_o,
  output logic [BYTE_W-1:0]   card_tx_data_o,
  output logic                card_wr_o,
  output logic [LEN_W:0]      byte_cnt_o,
  output logic [LEN_W:0]      blk_cnt_o,
  output logic                active_o,
  output logic                done_o
);
  logic      move, phase, last_byte, last_blk;
  xfer_dir_e dir;

  bbe_counters #(.LEN_W(LEN_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .len_we_i(len_we_i), .len_val_i(len_val_i),
    .cnt_we_i(cnt_we_i), .cnt_val_i(cnt_val_i),
    .step_i(move),
    .byte_cnt_o(byte_cnt_o), .blk_cnt_o(blk_cnt_o),
    .last_byte_o(last_byte), .last_blk_o(last_blk)
  );

  bbe_flow #(.FILL_W(FILL_W)) u_flow (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(start_i), .dir_i(dir_i),
    .hold_i(len_we_i || cnt_we_i),
    .card_rdy_i(card_rdy_i),
    .fill_i(buf_fill_i), .af_level_i(af_level_i),
    .last_byte_i(last_byte), .last_blk_i(last_blk),
    .move_o(move), .dir_o(dir), .phase_o(phase),
    .active_o(active_o), .done_o(done_o)
  );

  bbe_packer #(.BYTE_W(BYTE_W)) u_pack (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .move_i(move), .dir_i(dir), .phase_i(phase),
    .last_byte_i(last_byte),
    .rx_data_i(card_rx_data_i), .head_i(buf_head_i),
    .card_rd_o(card_rd_o), .card_wr_o(card_wr_o),
    .tx_data_o(card_tx_data_o),
    .push_o(buf_push_o), .push_data_o(buf_push_data_o),
    .pop_o(buf_pop_o)
  );
endmodule

// File: rtl/bbe_checker.sv
module bbe_checker #(
  parameter int LEN_W  = 11,
  parameter int FILL_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              len_we_i,
  input logic [LEN_W-1:0]  len_val_i,
  input logic              cnt_we_i,
  input logic [LEN_W-1:0]  cnt_val_i,
  input logic              start_i,
  input logic [FILL_W-1:0] buf_fill_i,
  input logic              buf_push_o,
  input logic              buf_pop_o,
  input logic              card_rdy_i,
  input logic              card_rd_o,
  input logic              card_wr_o,
  input logic [LEN_W:0]    byte_cnt_o,
  input logic [LEN_W:0]    blk_cnt_o,
  input logic              active_o,
  input logic              done_o
);
  assert_len_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_we_i |=> byte_cnt_o == (LEN_W+1)'($past(len_val_i)) + 1'b1);

  assert_cnt_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> blk_cnt_o == (LEN_W+1)'($past(cnt_val_i)) + 1'b1);

  assert_tx_not_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_wr_o |-> buf_fill_i != '0);

  assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(card_rd_o && card_wr_o) && !(buf_push_o && buf_pop_o));

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o || !card_rdy_i) |-> !card_rd_o && !card_wr_o);

  assert_blk_nonzero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_cnt_o != '0 && byte_cnt_o != '0);

  assert_end_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> done_o);

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_we_i || cnt_we_i || start_i) |-> !card_rd_o && !card_wr_o);
endmodule

bind blk_byte_engine bbe_checker #(.LEN_W(LEN_W), .FILL_W(FILL_W)) u_bbe_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .len_we_i(len_we_i), .len_val_i(len_val_i),
  .cnt_we_i(cnt_we_i), .cnt_val_i(cnt_val_i),
  .start_i(start_i), .buf_fill_i(buf_fill_i),
  .buf_push_o(buf_push_o), .buf_pop_o(buf_pop_o),
  .card_rdy_i(card_rdy_i), .card_rd_o(card_rd_o), .card_wr_o(card_wr_o),
  .byte_cnt_o(byte_cnt_o), .blk_cnt_o(blk_cnt_o),
  .active_o(active_o), .done_o(done_o)
);

// File: tb/blk_byte_engine_bench.sv
module blk_byte_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        len_we = 0, cnt_we = 0, start = 0, dir = 0, rdy = 0;
  logic [10:0] len_val = 0, cnt_val = 0;
  logic [4:0]  af = 5'd31;
  logic [5:0]  fill = 0;
  logic [15:0] head = 0;
  logic [7:0]  rx_byte = 8'h10;
  logic        push, pop, rd, wr, active, done;
  logic [15:0] push_data;
  logic [7:0]  tx_data;
  logic [11:0] byte_cnt, blk_cnt;

  int checks = 0, errors = 0;
  bit finished = 0;

  blk_byte_engine u_blk_byte_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .len_we_i(len_we), .len_val_i(len_val),
    .cnt_we_i(cnt_we), .cnt_val_i(cnt_val),
    .start_i(start), .dir_i(dir), .af_level_i(af),
    .buf_fill_i(fill), .buf_head_i(head),
    .buf_push_o(push), .buf_push_data_o(push_data), .buf_pop_o(pop),
    .card_rdy_i(rdy), .card_rx_data_i(rx_byte),
    .card_rd_o(rd), .card_tx_data_o(tx_data), .card_wr_o(wr),
    .byte_cnt_o(byte_cnt), .blk_cnt_o(blk_cnt),
    .active_o(active), .done_o(done)
  );

  always #4 clk = ~clk;

  // buffer stand-in and logs
  logic [15:0] bufq[$];
  logic [7:0]  txlog[$];
  bit          p_push, p_pop, p_rd;
  logic [15:0] p_data;
  int          n_rd = 0, n_wr = 0;

  // reference model state
  int  m_blen = 1, m_nblk = 1, m_bcnt = 1, m_kcnt = 1;
  bit  m_active = 0, m_rx = 0, m_phase = 0, m_done = 0, run_model = 0;
  int  m_lo = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sync_buf();
    fill = 6'(bufq.size());
    head = (bufq.size() != 0) ? bufq[0] : 16'h0;
  endtask

  always @(posedge clk) begin
    #1;
    if (p_pop && bufq.size() != 0) void'(bufq.pop_front());
    if (p_push) bufq.push_back(p_data);
    if (p_rd) rx_byte = rx_byte + 8'd1;
    p_push = 0; p_pop = 0; p_rd = 0;
    sync_buf();
  end

  always @(negedge clk) begin
    if (run_model) begin
      bit room, mv, we_end;
      int e_push_data, e_tx;
      chk(byte_cnt == 12'(m_bcnt), "R2/R3/R9 byte counter", byte_cnt, m_bcnt);
      chk(blk_cnt == 12'(m_kcnt), "R3/R9/R10 block counter", blk_cnt, m_kcnt);
      chk(active == m_active, "R10 active", active, m_active);
      chk(done == m_done, "R10 done", done, m_done);
      if (m_rx) room = m_phase || (int'(fill) <= int'(af));
      else      room = (fill != 0);
      mv = m_active && rdy && !len_we && !cnt_we && !start && room;
      we_end = m_phase || (m_bcnt == 1);
      chk(rd == (mv && m_rx), "R7/R8/R11 card read strobe", rd, mv && m_rx);
      chk(wr == (mv && !m_rx), "R7/R8/R11 card write strobe", wr, mv && !m_rx);
      chk(push == (mv && m_rx && we_end), "R4/R5 push strobe", push, mv && m_rx && we_end);
      chk(pop == (mv && !m_rx && we_end), "R6 pop strobe", pop, mv && !m_rx && we_end);
      if (mv && m_rx && we_end) begin
        e_push_data = m_phase ? (int'(rx_byte) << 8) | m_lo : int'(rx_byte);
        chk(int'(push_data) == e_push_data, "R4/R5 push data", push_data, e_push_data);
      end
      if (mv && !m_rx) begin
        e_tx = m_phase ? int'(head[15:8]) : int'(head[7:0]);
        chk(int'(tx_data) == e_tx, "R6 tx byte", tx_data, e_tx);
      end
      // strobes into the stand-in
      if (rd) begin n_rd++; p_rd = 1; end
      if (wr) begin n_wr++; txlog.push_back(tx_data); end
      if (push) begin p_push = 1; p_data = push_data; end
      if (pop) p_pop = 1;
      // model update
      if (len_we) begin m_blen = int'(len_val) + 1; m_bcnt = m_blen; end
      if (cnt_we) begin m_nblk = int'(cnt_val) + 1; m_kcnt = m_nblk; m_bcnt = m_blen; end
      if (start) begin m_active = 1; m_rx = dir; m_phase = 0; m_done = 0; end
      else if (mv) begin
        if (m_rx && !m_phase) m_lo = int'(rx_byte);
        if (m_bcnt == 1) begin
          m_bcnt = m_blen; m_phase = 0;
          if (m_kcnt == 1) begin m_kcnt = m_nblk; m_active = 0; m_done = 1; end
          else m_kcnt--;
        end else begin
          m_bcnt--; m_phase = !m_phase;
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr_len(input int v);
    len_we = 1; len_val = 11'(v); tick(); len_we = 0;
  endtask

  task automatic wr_cnt(input int v);
    cnt_we = 1; cnt_val = 11'(v); tick(); cnt_we = 0;
  endtask

  task automatic go(input bit d);
    dir = d; start = 1; tick(); start = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (active && guard < 5000) begin tick(); guard++; end
    tick();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(byte_cnt == 12'd1 && blk_cnt == 12'd1, "R1 counters", byte_cnt, 1);
    chk(!active && !done, "R1 active/done", {active, done}, 0);
    chk(!rd && !wr && !push && !pop, "R1 strobes", {rd, wr, push, pop}, 0);
    rst_n = 1;
    tick();
    run_model = 1;

    // R2/R3: 3-byte blocks, 2 blocks
    wr_len(2);
    @(negedge clk); chk(byte_cnt == 12'd3, "R2 length load", byte_cnt, 3);
    wr_cnt(1);
    @(negedge clk); chk(blk_cnt == 12'd2, "R3 count load", blk_cnt, 2);

    // R4/R5 receive with odd blocks
    rx_byte = 8'h10; rdy = 1; go(1);
    wait_idle();
    tick();
    chk(bufq.size() == 4, "R5 word count", bufq.size(), 4);
    if (bufq.size() == 4) begin
      chk(bufq[0] == 16'h1110, "R4 packed word", bufq[0], 16'h1110);
      chk(bufq[1] == 16'h0012, "R5 half word", bufq[1], 16'h0012);
      chk(bufq[2] == 16'h1413, "R4 second block word", bufq[2], 16'h1413);
      chk(bufq[3] == 16'h0015, "R5 second half word", bufq[3], 16'h0015);
    end
    chk(done && !active, "R10 done after rx", {done, active}, 2);
    chk(byte_cnt == 12'd3 && blk_cnt == 12'd2, "R10 reload", blk_cnt, 2);

    // R8 inactive with ready high
    n_rd = 0; n_wr = 0; repeat (4) tick();
    chk(n_rd == 0 && n_wr == 0, "R8 inactive quiet", n_rd + n_wr, 0);
    bufq.delete(); sync_buf();

    // R7 receive paused above almost-full level
    af = 5'd1; bufq.push_back(16'hAAAA); bufq.push_back(16'hBBBB); sync_buf();
    wr_len(3); wr_cnt(0);
    n_rd = 0; go(1); repeat (5) tick();
    chk(n_rd == 0, "R7 rx paused", n_rd, 0);
    bufq.delete(); sync_buf();
    wait_idle(); tick();
    chk(n_rd == 4 && bufq.size() == 2, "R7 rx resumed", n_rd, 4);
    bufq.delete(); sync_buf(); af = 5'd31;

    // R8 ready low
    rdy = 0; n_rd = 0; wr_len(1); go(1); repeat (4) tick();
    chk(n_rd == 0 && active, "R8 ready low quiet", n_rd, 0);
    // R11 config write mid-transfer suppresses the move
    rdy = 1; tick();
    len_we = 1; len_val = 11'd3; #1;
    chk(!rd, "R11 write holds move", rd, 0);
    tick(); len_we = 0;
    wait_idle(); tick();
    bufq.delete(); sync_buf();

    // R6 transmit, even block
    bufq.push_back(16'hA1B2); bufq.push_back(16'hC3D4); sync_buf();
    txlog.delete(); wr_len(3); wr_cnt(0); go(0);
    wait_idle(); tick();
    chk(txlog.size() == 4, "R6 tx count", txlog.size(), 4);
    if (txlog.size() == 4) begin
      chk(txlog[0] == 8'hB2 && txlog[1] == 8'hA1, "R6 low first", {txlog[0], txlog[1]}, 16'hB2A1);
      chk(txlog[2] == 8'hD4 && txlog[3] == 8'hC3, "R6 second word", {txlog[2], txlog[3]}, 16'hD4C3);
    end
    chk(bufq.size() == 0, "R6 all popped", bufq.size(), 0);

    // R6/R9 transmit, one-byte blocks pop each word
    bufq.push_back(16'h1122); bufq.push_back(16'h3344); sync_buf();
    txlog.delete(); wr_len(0); wr_cnt(1); go(0);
    wait_idle(); tick();
    chk(txlog.size() == 2 && bufq.size() == 0, "R6 odd pop", txlog.size(), 2);
    if (txlog.size() == 2)
      chk(txlog[0] == 8'h22 && txlog[1] == 8'h44, "R9 odd blocks", {txlog[0], txlog[1]}, 16'h2244);

    // R7 transmit paused while empty
    txlog.delete(); n_wr = 0; wr_len(1); wr_cnt(0); go(0); repeat (4) tick();
    chk(n_wr == 0 && active, "R7 tx empty pause", n_wr, 0);
    bufq.push_back(16'h5566); sync_buf();
    wait_idle(); tick();
    chk(txlog.size() == 2 && done, "R7 tx resumed", txlog.size(), 2);
    if (txlog.size() == 2)
      chk(txlog[0] == 8'h66 && txlog[1] == 8'h55, "R6 resumed order", {txlog[0], txlog[1]}, 16'h6655);

    // R10 done clears on start
    go(0); @(negedge clk);
    chk(!done && active, "R10 done clear", {done, active}, 1);
    rdy = 0; repeat (2) tick();
    summary();
  end
endmodule